// File: doc/BRIEF.md
# Hardware Breakpoint Unit

This block watches CPU bus activity against six 16-bit breakpoint values and raises a one-cycle break request to the debug engine when a qualified match occurs. Slots 0 to 3 compare only against the instruction fetch address. Slots 4 and 5 are dual-purpose. A control bit selects whether they compare against the data memory address or against a register access, given as a 4-bit module and a 5-bit index.

The breakpoint values and the control bits are loaded over a byte-wide command stream. Each command is an opcode byte followed by its data bytes, sent low byte first. A breakpoint only takes its new value once its last data byte has arrived. A separate opcode asks for a halt, and the halt request is issued only at the next instruction boundary. Both a power-on reset and a test-logic reset return every breakpoint to all ones.

Top module: `hw_brk_unit`

## Requirements
- R1: After `rst`, all six breakpoints hold 0xFFFF, both control bits are 0, and `break_req` and `halt_req` are low.
- R2: Opcode 0x15+n (n = 0..5) writes slot n. It takes two data bytes, low byte first.
- R3: A slot keeps its old value until the final data byte of its write command is accepted. The new value is used for matching from the next cycle.
- R4: Slots 0 to 3 match only when `fetch_valid` is high and `fetch_addr` equals the slot value. Data and register accesses never trigger them.
- R5: With the register-match bit clear, slots 4 and 5 match when `dacc_valid` is high and `dacc_addr` equals the slot value. Fetches never trigger them.
- R6: With the register-match bit set, slots 4 and 5 match when `racc_valid` is high, `racc_module` equals slot bits 3:0 and `racc_index` equals slot bits 8:4. Slot bits 15:9 and the data address are ignored.
- R7: No break request is produced while the enable bit is clear.
- R8: `break_req` rises in the cycle after a qualified match. It is a single-bit request even when several slots match in the same cycle.
- R9: Opcode 0x14 followed by one data byte loads the control bits: bit 0 is the enable bit, bit 1 is the register-match bit. These bits are cleared only by `rst`.
- R10: Opcode 0x1F sets a pending halt. `halt_req` pulses for one cycle in the cycle after the next `insn_done`, and the pending halt then clears.
- R11: An opcode byte that is not recognised has no effect, and the following byte is taken as a new opcode.
- R12: `tlr` sets all breakpoints to 0xFFFF and returns the command decoder to the opcode state. It leaves the control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| tlr | input | 1 | Synchronous test-logic reset, active high |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte (opcode or data) |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 16 | Program fetch address |
| dacc_valid | input | 1 | Data memory access strobe |
| dacc_addr | input | 16 | Data memory address |
| racc_valid | input | 1 | Register access strobe |
| racc_module | input | 4 | Register access module specifier |
| racc_index | input | 5 | Register access index |
| insn_done | input | 1 | Instruction boundary strobe |
| break_req | output | 1 | Registered one-cycle break request |
| halt_req | output | 1 | Registered one-cycle halt request |

## Verification
Fetch, data and register probes are aimed at the same address values. This separates which bus each slot listens to, and shows that the mode bit moves the upper slots between buses. Register probes change only the module or only the index, and use a slot whose upper bits are non-zero, so the field layout and the ignored bits are each pinned down. Half-sent writes, unknown opcodes placed before a valid write, and a test-logic reset in the middle of a command show when a value lands and how the decoder resynchronises. The enable bit and the halt pending state are probed before and after each change.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam logic [7:0] OP_CTRL    = 8'h14;
  localparam logic [7:0] OP_BP_BASE = 8'h15;
  localparam logic [7:0] OP_DEBUG   = 8'h1F;

  typedef enum logic {LD_IDLE, LD_DATA} ld_state_e;
endpackage

// File: rtl/brk_cmd_loader.sv
module brk_cmd_loader
  import brk_pkg::*;
#(
  parameter int NUM_BP = 6,
  parameter int DATA_W = 16,
  parameter int IDX_W  = $clog2(NUM_BP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  output logic              bp_wr_en,
  output logic [IDX_W-1:0]  bp_wr_idx,
  output logic [DATA_W-1:0] bp_wr_data,
  output logic              ctrl_wr_en,
  output logic              dbg_cmd
);
  localparam int NBYTES = DATA_W / 8;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  ld_state_e         state_q;
  logic [7:0]        op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              is_ctrl_q;
  logic              dbg_q;
  logic              op_is_bp, op_is_ctrl, last_byte;

  always_comb begin
    op_is_bp   = (int'(cmd_byte) >= int'(OP_BP_BASE)) &&
                 (int'(cmd_byte) <  int'(OP_BP_BASE) + NUM_BP);
    op_is_ctrl = (cmd_byte == OP_CTRL);
    last_byte  = (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= LD_IDLE;
      op_q      <= '0;
      cnt_q     <= '0;
      sh_q      <= '0;
      is_ctrl_q <= 1'b0;
      dbg_q     <= 1'b0;
    end else begin
      dbg_q <= 1'b0;
      if (cmd_valid) begin
        if (state_q == LD_IDLE) begin
          if (op_is_bp || op_is_ctrl) begin
            state_q   <= LD_DATA;
            op_q      <= cmd_byte;
            is_ctrl_q <= op_is_ctrl;
            cnt_q     <= op_is_ctrl ? CNT_W'(1) : CNT_W'(NBYTES);
          end else if (cmd_byte == OP_DEBUG) begin
            dbg_q <= 1'b1;
          end
        end else begin
          sh_q  <= {cmd_byte, sh_q[DATA_W-1:8]};
          cnt_q <= cnt_q - CNT_W'(1);
          if (last_byte) state_q <= LD_IDLE;
        end
      end
    end
  end

  assign bp_wr_en   = cmd_valid && (state_q == LD_DATA) && last_byte && !is_ctrl_q;
  assign ctrl_wr_en = cmd_valid && (state_q == LD_DATA) && last_byte && is_ctrl_q;
  assign bp_wr_idx  = IDX_W'(op_q - OP_BP_BASE);
  assign bp_wr_data = {cmd_byte, sh_q[DATA_W-1:8]};
  assign dbg_cmd    = dbg_q;

  assert_wr_on_last_R3: assert property (@(posedge clk) disable iff (rst)
    (bp_wr_en || ctrl_wr_en) |=> (state_q == LD_IDLE));
  assert_one_action_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bp_wr_en, ctrl_wr_en, dbg_q}));
endmodule

// File: rtl/brk_match_slot.sv
module brk_match_slot #(
  parameter int DATA_W = 16,
  parameter int MOD_W  = 4,
  parameter int RIDX_W = 5
) (
  input  logic              reg_mode,
  input  logic [DATA_W-1:0] bp_val,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] a_addr,
  input  logic              r_valid,
  input  logic [MOD_W-1:0]  r_module,
  input  logic [RIDX_W-1:0] r_index,
  output logic              hit
);
  logic addr_hit, reg_hit;

  always_comb begin
    addr_hit = a_valid && (a_addr == bp_val);
    reg_hit  = r_valid && (r_module == bp_val[MOD_W-1:0]) &&
               (r_index == bp_val[MOD_W+RIDX_W-1:MOD_W]);
    hit      = reg_mode ? reg_hit : addr_hit;
  end
endmodule

// File: rtl/brk_halt_ctrl.sv
module brk_halt_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic dbg_cmd,
  input  logic insn_done,
  output logic halt_req
);
  logic pend_q, halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      halt_q <= pend_q && insn_done;
      pend_q <= dbg_cmd || (pend_q && !insn_done);
    end
  end

  assign halt_req = halt_q;

  assert_halt_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !halt_req);
  assert_halt_needs_pend_R10: assert property (@(posedge clk) disable iff (rst)
    (!pend_q) |=> !halt_req);
endmodule

// File: rtl/hw_brk_unit.sv
module hw_brk_unit
  import brk_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_PC  = 4,
  parameter int NUM_DU  = 2,
  parameter int MOD_W   = 4,
  parameter int RIDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tlr,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_addr,
  input  logic              dacc_valid,
  input  logic [DATA_W-1:0] dacc_addr,
  input  logic              racc_valid,
  input  logic [MOD_W-1:0]  racc_module,
  input  logic [RIDX_W-1:0] racc_index,
  input  logic              insn_done,
  output logic              break_req,
  output logic              halt_req
);
  localparam int NUM_BP = NUM_PC + NUM_DU;
  localparam int IDX_W  = $clog2(NUM_BP);

  logic              bp_wr_en, ctrl_wr_en, dbg_cmd;
  logic [IDX_W-1:0]  bp_wr_idx;
  logic [DATA_W-1:0] bp_wr_data;
  logic [DATA_W-1:0] bp_q [NUM_BP];
  logic [NUM_BP-1:0] hits;
  logic              dme_q, rege_q, brk_q;

  brk_cmd_loader #(.NUM_BP(NUM_BP), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_loader (
    .clk(clk), .rst(rst || tlr), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .bp_wr_en(bp_wr_en), .bp_wr_idx(bp_wr_idx), .bp_wr_data(bp_wr_data),
    .ctrl_wr_en(ctrl_wr_en), .dbg_cmd(dbg_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dme_q  <= 1'b0;
      rege_q <= 1'b0;
    end else if (ctrl_wr_en) begin
      dme_q  <= cmd_byte[0];
      rege_q <= cmd_byte[1];
    end
  end

  for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
    localparam bit DUAL = (g >= NUM_PC);

    always_ff @(posedge clk) begin
      if (rst || tlr)                                  bp_q[g] <= '1;
      else if (bp_wr_en && bp_wr_idx == IDX_W'(g))     bp_q[g] <= bp_wr_data;
    end

    brk_match_slot #(.DATA_W(DATA_W), .MOD_W(MOD_W), .RIDX_W(RIDX_W)) u_slot (
      .reg_mode (DUAL ? rege_q : 1'b0),
      .bp_val   (bp_q[g]),
      .a_valid  (DUAL ? dacc_valid : fetch_valid),
      .a_addr   (DUAL ? dacc_addr : fetch_addr),
      .r_valid  (DUAL ? racc_valid : 1'b0),
      .r_module (racc_module),
      .r_index  (racc_index),
      .hit      (hits[g])
    );

    assert_tlr_ones_R12: assert property (@(posedge clk) disable iff (rst)
      tlr |=> (bp_q[g] == '1));
  end

  always_ff @(posedge clk) begin
    if (rst) brk_q <= 1'b0;
    else     brk_q <= dme_q && (|hits);
  end
  assign break_req = brk_q;

  brk_halt_ctrl u_halt (
    .clk(clk), .rst(rst), .dbg_cmd(dbg_cmd), .insn_done(insn_done), .halt_req(halt_req)
  );

  assert_dme_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (!dme_q) |=> !break_req);
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr_en) |=> $stable({dme_q, rege_q}));
endmodule

// File: tb/test_hw_brk_unit.sv
module test_hw_brk_unit;
  logic        clk = 1'b0;
  logic        rst, tlr, cmd_valid, fetch_valid, dacc_valid, racc_valid, insn_done;
  logic [7:0]  cmd_byte;
  logic [15:0] fetch_addr, dacc_addr;
  logic [3:0]  racc_module;
  logic [4:0]  racc_index;
  logic        break_req, halt_req;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  hw_brk_unit i_hw_brk_unit (
    .clk(clk), .rst(rst), .tlr(tlr), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .dacc_valid(dacc_valid),
    .dacc_addr(dacc_addr), .racc_valid(racc_valid), .racc_module(racc_module),
    .racc_index(racc_index), .insn_done(insn_done), .break_req(break_req),
    .halt_req(halt_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic write_bp(input int n, input logic [15:0] v);
    send(8'h15 + 8'(n)); send(v[7:0]); send(v[15:8]);
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    send(8'h14); send(v);
  endtask

  task automatic probe_fetch(input logic [15:0] a, input bit exp, input string req);
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    chk(break_req == exp, req, int'(break_req), int'(exp));
  endtask

  task automatic probe_data(input logic [15:0] a, input bit exp, input string req);
    dacc_valid = 1'b1; dacc_addr = a;
    @(negedge clk);
    dacc_valid = 1'b0;
    chk(break_req == exp, req, int'(break_req), int'(exp));
  endtask

  task automatic probe_reg(input logic [3:0] m, input logic [4:0] x, input bit exp, input string req);
    racc_valid = 1'b1; racc_module = m; racc_index = x;
    @(negedge clk);
    racc_valid = 1'b0;
    chk(break_req == exp, req, int'(break_req), int'(exp));
  endtask

  task automatic t_reset;
    chk(break_req == 1'b0, "R1", int'(break_req), 0);
    chk(halt_req == 1'b0, "R1", int'(halt_req), 0);
    probe_fetch(16'hFFFF, 1'b0, "R7 enable clear");
    write_ctrl(8'h01);
    probe_fetch(16'hFFFF, 1'b1, "R1 ones fetch");
    probe_data(16'hFFFF, 1'b1, "R1 ones data");
  endtask

  task automatic t_pc_slots;
    for (int n = 0; n < 4; n++) write_bp(n, 16'h1000 + 16'(n * 'h111));
    for (int n = 0; n < 4; n++) probe_fetch(16'h1000 + 16'(n * 'h111), 1'b1, "R2 R4 slot");
    probe_data(16'h1000, 1'b0, "R4 data ignored");
    probe_reg(4'h0, 5'h0, 1'b0, "R4 reg ignored");
    probe_fetch(16'hFFFF, 1'b0, "R5 upper slots ignore fetch");
  endtask

  task automatic t_partial;
    send(8'h16); send(8'h34);
    probe_fetch(16'h1111, 1'b1, "R3 old value kept");
    send(8'h12);
    probe_fetch(16'h1234, 1'b1, "R3 new value");
    probe_fetch(16'h1111, 1'b0, "R3 old value gone");
  endtask

  task automatic t_data;
    write_bp(4, 16'h2000); write_bp(5, 16'h2002);
    probe_data(16'h2000, 1'b1, "R5 slot4");
    probe_data(16'h2002, 1'b1, "R5 slot5");
    probe_data(16'h2004, 1'b0, "R5 miss");
    probe_fetch(16'h2000, 1'b0, "R5 fetch ignored");
  endtask

  task automatic t_regmode;
    write_bp(4, 16'hFE5A);
    write_ctrl(8'h03);
    probe_reg(4'hA, 5'h05, 1'b1, "R6 module+index");
    probe_reg(4'hA, 5'h06, 1'b0, "R6 index differs");
    probe_reg(4'hB, 5'h05, 1'b0, "R6 module differs");
    probe_data(16'hFE5A, 1'b0, "R6 data ignored");
    probe_reg(4'h2, 5'h00, 1'b1, "R6 slot5");
    write_ctrl(8'h01);
    probe_data(16'h2002, 1'b1, "R9 mode back");
  endtask

  task automatic t_multi;
    write_bp(0, 16'h3000); write_bp(2, 16'h3000);
    fetch_valid = 1'b1; fetch_addr = 16'h3000;
    #1;
    chk(break_req == 1'b0, "R8 registered", int'(break_req), 0);
    @(negedge clk);
    fetch_valid = 1'b0;
    chk(break_req == 1'b1, "R8 one later", int'(break_req), 1);
    @(negedge clk);
    chk(break_req == 1'b0, "R8 single pulse", int'(break_req), 0);
  endtask

  task automatic t_gate;
    write_ctrl(8'h00);
    probe_fetch(16'h3000, 1'b0, "R7 disabled");
    write_ctrl(8'h01);
    probe_fetch(16'h3000, 1'b1, "R9 enabled");
  endtask

  task automatic t_unknown;
    send(8'h30); send(8'h1E);
    write_bp(0, 16'hABCD);
    probe_fetch(16'hABCD, 1'b1, "R11 next byte is opcode");
  endtask

  task automatic t_halt;
    send(8'h1F);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(halt_req == 1'b0, "R10 waits boundary", int'(halt_req), 0);
    end
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    chk(halt_req == 1'b1, "R10 halt", int'(halt_req), 1);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    chk(halt_req == 1'b0, "R10 pending cleared", int'(halt_req), 0);
  endtask

  task automatic t_tlr;
    send(8'h15); send(8'h11);
    tlr = 1'b1;
    @(negedge clk);
    tlr = 1'b0;
    probe_fetch(16'hFFFF, 1'b1, "R12 ones, enable kept");
    probe_fetch(16'hABCD, 1'b0, "R12 old value cleared");
    write_bp(1, 16'h3322);
    probe_fetch(16'h3322, 1'b1, "R12 decoder idle");
  endtask

  initial begin
    rst = 1'b1; tlr = 1'b0; cmd_valid = 1'b0; cmd_byte = '0;
    fetch_valid = 1'b0; fetch_addr = '0; dacc_valid = 1'b0; dacc_addr = '0;
    racc_valid = 1'b0; racc_module = '0; racc_index = '0; insn_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pc_slots();
    t_partial();
    t_data();
    t_regmode();
    t_multi();
    t_gate();
    t_unknown();
    t_halt();
    t_tlr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule